// File: doc/BRIEF.md
# DDR4 Self-Refresh Entry/Exit Sequencer

This block takes a DIMM's ranks into self-refresh, or brings them back out, by driving a command stream and a 4-bit clock-enable (CKE) vector toward the DDR interface. Software gives it a one-cycle start pulse, a direction bit, an 8-slot rank-present mask and the DLL lock time in clocks. From these it sequences the periodic-refresh enable and the address-mux-select flag. It issues one self-refresh command to each present rank, lowest slot first, and keeps the required idle time after each command. It then closes the run with a deselect that carries the last command's CKE. That CKE value stays on the pins after the run ends, so the DIMM stays in the state it was put in.

During entry, each command also keeps CKE low on the ranks that have already been put to sleep. During exit, CKE is only ever raised, so no rank that is already awake can drop into power-down. The entry idle time comes from the clock period, which is an elaboration parameter. The exit idle time is the DLL lock time that software supplies.

Top module: `sr_seq`

## Requirements
- R1: After reset: `cke_o`=4'b1111, `refresh_en_o`=1, `addr_mux_sel_o`=0, and `busy_o`, `done_o` and `cmd_valid_o` are all 0.
- R2: A start pulse taken while idle raises `busy_o` on the next cycle. On entry (`exit_i`=0), `refresh_en_o` goes to 0 and `addr_mux_sel_o` goes to 1 in that same cycle. On exit, `addr_mux_sel_o` goes to 0. The first command follows one cycle later.
- R3: Exactly one command is issued per set bit of `rank_mask_i`, in ascending slot order. `cmd_o` encodes deselect as 0, self-refresh entry as 1 and self-refresh exit as 2. `cmd_rank_o` carries the slot number.
- R4: An entry command drives `cke_o` = previous `cke_o` AND the slot pattern. The patterns, written MSB first, are: slot 0 0111, slot 1 1011, slot 4 1101, slot 5 1110, and 0000 for slots 2, 3, 6 and 7.
- R5: An exit command drives `cke_o` = previous `cke_o` OR the slot pattern. The patterns are: slot 0 1000, slot 1 0100, slot 4 0010, slot 5 0001, and 0000 for slots 2, 3, 6 and 7.
- R6: During entry, each command (and the trailing deselect) follows the previous command by tCKESR = max(3, ceil(5000 ps / CLK_PS)) + 1 cycles. With the default CLK_PS=1250 this is 5 cycles.
- R7: During exit, the spacing is `tdllk_i` cycles, latched at start. A value of 0 is treated as 1.
- R8: After the last command's idle time, a deselect is issued with `cke_o` unchanged. `cke_o` changes only in cycles that carry an entry or exit command, and it holds its value after the run ends.
- R9: With an empty mask, no command and no deselect are issued and `cke_o` keeps its value. `done_o` pulses two cycles after the start edge.
- R10: `done_o` is high for exactly one cycle, the cycle after the deselect, and `busy_o` is low in that cycle. After an exit, `refresh_en_o` returns to 1 in that same cycle and not earlier.
- R11: A start pulse that arrives while busy (including the deselect cycle) is ignored. A start pulse in the `done_o` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| exit_i | input | 1 | 0 = enter self-refresh, 1 = exit |
| rank_mask_i | input | 8 | Rank-present mask, one bit per slot |
| tdllk_i | input | 12 | DLL lock time in clocks, used as the exit idle count |
| cmd_valid_o | output | 1 | Command or deselect present this cycle |
| cmd_o | output | 2 | Command code: 0 deselect, 1 entry, 2 exit |
| cmd_rank_o | output | 3 | Target slot of the command |
| cke_o | output | 4 | Clock-enable vector |
| refresh_en_o | output | 1 | Periodic refresh enable |
| addr_mux_sel_o | output | 1 | Select that latches the last bus CKE state |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The closing of one run and the opening of the next can fall in the same cycle: the `done_o` cycle is also the first cycle in which a new start is sampled. The bench holds `start_i` high across a whole entry run. It then checks three things: only one command was issued during that run, the deselect cycle did not restart the block, and `busy_o` is high again on the cycle after `done_o`. A second collision is a start pulse with a different direction and mask that lands in the middle of a run's idle wait. It is judged by checking that the remaining commands still follow the mask latched at the original start.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_DES = 2'd0,
    CMD_SRE = 2'd1,
    CMD_SRX = 2'd2
  } sr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sr_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sr_cke_map.sv
module sr_cke_map #(
  parameter int NUM_SLOTS = 8,
  parameter int CKE_W     = 4,
  localparam int RANK_W   = $clog2(NUM_SLOTS)
) (
  input  logic [RANK_W-1:0] slot_i,
  input  logic              exit_i,
  output logic [CKE_W-1:0]  pat_o
);

  logic [CKE_W-1:0] ent_tab [NUM_SLOTS];
  logic [CKE_W-1:0] ext_tab [NUM_SLOTS];

  // slots 0,1 of each group of four own one CKE bit, MSB first
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int IDX = 2 * (s / 4) + (s % 2);
    if (((s % 4) < 2) && (IDX < CKE_W)) begin : g_owned
      localparam logic [CKE_W-1:0] BIT = {{(CKE_W-1){1'b0}}, 1'b1} << (CKE_W - 1 - IDX);
      assign ent_tab[s] = ~BIT;
      assign ext_tab[s] = BIT;
    end else begin : g_none
      assign ent_tab[s] = '0;
      assign ext_tab[s] = '0;
    end
  end

  assign pat_o = exit_i ? ext_tab[slot_i] : ent_tab[slot_i];

endmodule

// File: rtl/sr_rank_pick.sv
module sr_rank_pick #(
  parameter int NUM_SLOTS = 8,
  localparam int RANK_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] mask_i,
  input  logic [RANK_W:0]      from_i,
  output logic                 found_o,
  output logic [RANK_W-1:0]    slot_o
);

  logic [NUM_SLOTS-1:0] elig;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_elig
    localparam logic [RANK_W:0] SV = s;
    assign elig[s] = mask_i[s] && (SV >= from_i);
  end

  always_comb begin
    found_o = 1'b0;
    slot_o  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (elig[s]) begin
        found_o = 1'b1;
        slot_o  = RANK_W'(s);
      end
    end
  end

endmodule

// File: rtl/sr_idle_timer.sv
module sr_idle_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R6 R7
  load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));

  // R6 R7
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import sr_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CKE_W     = 4,
  parameter int CLK_PS    = 1250,
  parameter int DLL_W     = 12,
  localparam int RANK_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 exit_i,
  input  logic [NUM_SLOTS-1:0] rank_mask_i,
  input  logic [DLL_W-1:0]     tdllk_i,
  output logic                 cmd_valid_o,
  output logic [1:0]           cmd_o,
  output logic [RANK_W-1:0]    cmd_rank_o,
  output logic [CKE_W-1:0]     cke_o,
  output logic                 refresh_en_o,
  output logic                 addr_mux_sel_o,
  output logic                 busy_o,
  output logic                 done_o
);

  localparam int TCKE_5NS = int'(ceil_div(5000, CLK_PS));
  localparam int TCKE     = (TCKE_5NS > 3) ? TCKE_5NS : 3;
  localparam int TCKESR   = TCKE + 1;
  localparam int SR_W     = $clog2(TCKESR + 1);
  localparam int CNT_W    = (DLL_W > SR_W) ? DLL_W : SR_W;

  sr_state_e            state_q;
  logic                 exit_q;
  logic [NUM_SLOTS-1:0] mask_q;
  logic [DLL_W-1:0]     tdllk_q;
  logic [RANK_W:0]      next_q;
  logic                 issued_q;
  logic                 cmd_valid_q;
  sr_cmd_e              cmd_q;
  logic [RANK_W-1:0]    rank_q;
  logic [CKE_W-1:0]     cke_q;
  logic                 ref_en_q;
  logic                 mux_q;
  logic                 done_q;

  logic                 pick_found;
  logic [RANK_W-1:0]    pick_slot;
  logic [CKE_W-1:0]     pat;
  logic [CKE_W-1:0]     cke_new;
  logic [CNT_W-1:0]     idle_val;
  logic                 expired;
  logic                 issue_cmd;
  logic                 run_end;

  sr_rank_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .mask_i  (mask_q),
    .from_i  (next_q),
    .found_o (pick_found),
    .slot_o  (pick_slot)
  );

  sr_cke_map #(.NUM_SLOTS(NUM_SLOTS), .CKE_W(CKE_W)) u_map (
    .slot_i (pick_slot),
    .exit_i (exit_q),
    .pat_o  (pat)
  );

  sr_idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (issue_cmd),
    .load_val_i (idle_val),
    .expired_o  (expired)
  );

  // entry keeps sleeping ranks low, exit never lowers an awake rank
  assign cke_new   = exit_q ? (cke_q | pat) : (cke_q & pat);
  assign idle_val  = exit_q ? ((tdllk_q == '0) ? CNT_W'(1) : CNT_W'(tdllk_q))
                            : CNT_W'(TCKESR);
  assign issue_cmd = (state_q == ST_RUN) && expired && pick_found;
  assign run_end   = (state_q == ST_RUN) && expired && !pick_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      exit_q      <= 1'b0;
      mask_q      <= '0;
      tdllk_q     <= '0;
      next_q      <= '0;
      issued_q    <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_q       <= CMD_DES;
      rank_q      <= '0;
      cke_q       <= '1;
      ref_en_q    <= 1'b1;
      mux_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      cmd_valid_q <= 1'b0;
      done_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_RUN;
            exit_q   <= exit_i;
            mask_q   <= rank_mask_i;
            tdllk_q  <= tdllk_i;
            next_q   <= '0;
            issued_q <= 1'b0;
            if (!exit_i) begin
              ref_en_q <= 1'b0;
              mux_q    <= 1'b1;
            end else begin
              mux_q    <= 1'b0;
            end
          end
        end
        ST_RUN: begin
          if (issue_cmd) begin
            cmd_valid_q <= 1'b1;
            cmd_q       <= exit_q ? CMD_SRX : CMD_SRE;
            rank_q      <= pick_slot;
            cke_q       <= cke_new;
            next_q      <= (RANK_W+1)'(pick_slot) + 1'b1;
            issued_q    <= 1'b1;
          end else if (run_end) begin
            state_q <= ST_FIN;
            if (issued_q) begin
              cmd_valid_q <= 1'b1;
              cmd_q       <= CMD_DES;
            end
          end
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (exit_q) ref_en_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o    = cmd_valid_q;
  assign cmd_o          = cmd_q;
  assign cmd_rank_o     = rank_q;
  assign cke_o          = cke_q;
  assign refresh_en_o   = ref_en_q;
  assign addr_mux_sel_o = mux_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;

  // checker state: last slot commanded in the current run
  logic              chk_have_q;
  logic [RANK_W-1:0] chk_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_have_q <= 1'b0;
      chk_last_q <= '0;
    end else if (state_q == ST_IDLE && start_i) begin
      chk_have_q <= 1'b0;
    end else if (cmd_valid_q && cmd_q != CMD_DES) begin
      chk_have_q <= 1'b1;
      chk_last_q <= rank_q;
    end
  end

  // R3
  rank_ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o != CMD_DES && chk_have_q) |-> (cmd_rank_o > chk_last_q));

  // R8
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && cmd_o != CMD_DES) |-> $stable(cke_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2
  entry_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !exit_q) |-> (!refresh_en_o && addr_mux_sel_o));

  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(mask_q) && $stable(exit_q)));

  // R3
  cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);

endmodule

// File: tb/sr_seq_tb.sv
`timescale 1ns/1ps
module sr_seq_tb;

  localparam int CLK_PS_DUT = 1250;
  localparam int T5 = (5000 + CLK_PS_DUT - 1) / CLK_PS_DUT;
  localparam int TCKESR_EXP = ((T5 > 3) ? T5 : 3) + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       exit_i = 1'b0;
  logic [7:0] rank_mask_i = '0;
  logic [11:0] tdllk_i = '0;
  logic       cmd_valid_o;
  logic [1:0] cmd_o;
  logic [2:0] cmd_rank_o;
  logic [3:0] cke_o;
  logic       refresh_en_o;
  logic       addr_mux_sel_o;
  logic       busy_o;
  logic       done_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [3:0] cke_m = 4'b1111;
  logic       ref_m = 1'b1;

  always #2 clk = ~clk;

  sr_seq #(.CLK_PS(CLK_PS_DUT)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start_i),
    .exit_i         (exit_i),
    .rank_mask_i    (rank_mask_i),
    .tdllk_i        (tdllk_i),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_o          (cmd_o),
    .cmd_rank_o     (cmd_rank_o),
    .cke_o          (cke_o),
    .refresh_en_o   (refresh_en_o),
    .addr_mux_sel_o (addr_mux_sel_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ent_pat(input int s);
    case (s)
      0: return 4'b0111;
      1: return 4'b1011;
      4: return 4'b1101;
      5: return 4'b1110;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] ext_pat(input int s);
    case (s)
      0: return 4'b1000;
      1: return 4'b0100;
      4: return 4'b0010;
      5: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cke", int'(cke_o), 15);
    chk("R1 refresh", int'(refresh_en_o), 1);
    chk("R1 mux", int'(addr_mux_sel_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 valid", int'(cmd_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // poke: cycle at which a conflicting start is pulsed mid-run (0 = none)
  task automatic run_seq(input logic ex, input logic [7:0] mask, input logic [11:0] dll, input int poke);
    int cyc, last_cmd, des_cyc, nxt, gap, exp_done;
    bit first;
    logic [3:0] pred;
    gap = ex ? ((dll == 0) ? 1 : int'(dll)) : TCKESR_EXP;
    start_i = 1'b1; exit_i = ex; rank_mask_i = mask; tdllk_i = dll;
    @(negedge clk);
    start_i = 1'b0;
    if (!ex) ref_m = 1'b0;
    chk("R2 busy", int'(busy_o), 1);
    chk("R2 mux", int'(addr_mux_sel_o), int'(!ex));
    chk("R2 refresh", int'(refresh_en_o), int'(ref_m));
    chk("R2 no cmd yet", int'(cmd_valid_o), 0);
    cyc = 0; last_cmd = 0; des_cyc = 0; nxt = 0; first = 1'b1;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      cyc++;
      if (poke != 0 && cyc == poke) begin
        start_i = 1'b1; exit_i = !ex; rank_mask_i = 8'hFF;
      end else begin
        start_i = 1'b0; exit_i = ex; rank_mask_i = mask;
      end
      if (cmd_valid_o && cmd_o != 2'd0) begin
        while (nxt < 8 && !mask[nxt]) nxt++;
        chk("R3 rank", int'(cmd_rank_o), nxt);
        chk("R3 code", int'(cmd_o), ex ? 2 : 1);
        pred = ex ? (cke_m | ext_pat(nxt)) : (cke_m & ent_pat(nxt));
        chk(ex ? "R5 cke" : "R4 cke", int'(cke_o), int'(pred));
        chk(first ? "R2 first" : (ex ? "R7 gap" : "R6 gap"), cyc - last_cmd, first ? 1 : gap);
        cke_m = pred; last_cmd = cyc; nxt++; first = 1'b0;
      end else if (cmd_valid_o) begin
        while (nxt < 8 && !mask[nxt]) nxt++;
        chk("R3 all ranks", nxt, 8);
        chk(ex ? "R7 des gap" : "R6 des gap", cyc - last_cmd, gap);
        chk("R8 des cke", int'(cke_o), int'(cke_m));
        des_cyc = cyc;
      end else begin
        if (cke_o != cke_m) chk("R8 hold", int'(cke_o), int'(cke_m));
      end
      if (done_o) begin
        exp_done = (mask == 0) ? 2 : des_cyc + 1;
        chk((mask == 0) ? "R9 done" : "R10 done", cyc, exp_done);
        chk("R10 busy", int'(busy_o), 0);
        if (ex) ref_m = 1'b1;
        chk("R10 refresh", int'(refresh_en_o), int'(ref_m));
        chk("R9 cke", int'(cke_o), int'(cke_m));
        break;
      end else if (refresh_en_o != ref_m) begin
        chk("R10 early refresh", int'(refresh_en_o), int'(ref_m));
      end
    end
    start_i = 1'b0;
    @(negedge clk);
    chk("R10 pulse", int'(done_o), 0);
    chk("R11 stays idle", int'(busy_o), 0);
  endtask

  task automatic t_overlap();
    int n_cmd;
    n_cmd = 0;
    start_i = 1'b1; exit_i = 1'b0; rank_mask_i = 8'h10;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (cmd_valid_o && cmd_o == 2'd1) n_cmd++;
      if (done_o) break;
    end
    chk("R11 one cmd per run", n_cmd, 1);
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 restart in done cycle", int'(busy_o), 1);
    n_cmd = 0;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (cmd_valid_o && cmd_o == 2'd1) n_cmd++;
      if (done_o) break;
    end
    chk("R11 second run", n_cmd, 1);
    cke_m = cke_m & 4'b1101;
    ref_m = 1'b0;
    chk("R4 overlap cke", int'(cke_o), int'(cke_m));
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    run_seq(1'b0, 8'h33, 12'd0, 0);
    run_seq(1'b1, 8'h33, 12'd7, 0);
    run_seq(1'b0, 8'hA5, 12'd0, 3);
    run_seq(1'b1, 8'h12, 12'd1, 0);
    run_seq(1'b1, 8'h08, 12'd0, 0);
    run_seq(1'b0, 8'h00, 12'd0, 0);
    run_seq(1'b1, 8'h21, 12'd3, 2);
    t_overlap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule